// File: doc/BRIEF.md
# Process-Tagged Associative Translation Buffer

This block keeps a small, fully associative set of recent virtual-to-physical page mappings for several processes at once. A lookup presents a 20-bit virtual page number, a 12-bit page offset, a process identifier, the kind of access (read, write or execute) and whether the requester runs in supervisor mode. One cycle later the block reports a hit with the translated physical address, a miss, or an access fault. Each cached mapping is tagged with its process identifier, so a context switch can leave entries in place, drop only one process's entries, or drop everything.

Mappings are installed through a fill port once a page table walk has found them. A fill goes into the entry that already holds the same process and page if there is one, otherwise into the lowest free entry, otherwise into an entry chosen by a free-running pseudo-random counter. Each entry carries read, write, execute and supervisor-only permission bits plus a dirty bit. A writable page that is still clean faults on its first write, so the miss handler can record dirty state and refill the entry with dirty set.

Top module: `ptag_tlb`

## Requirements
- R1: The response appears one clock after the lookup request; on a hit, rsp_paddr is the entry's physical page number with the request offset appended unchanged in the low 12 bits; on a miss or fault rsp_paddr is zero.
- R2: A hit needs a valid entry whose page number and process identifier both equal the request; the same page number under another process, or a neighbouring page number, misses.
- R3: The buffer holds 16 entries and any mapping may sit in any of them: 16 distinct mappings filled into an empty buffer all hit afterwards.
- R4: Access code 2'b00 (read) needs the read bit, 2'b01 (write) the write bit, 2'b10 (execute) the execute bit; code 2'b11 always faults. A missing permission raises rsp_fault with rsp_hit low.
- R5: An entry marked supervisor-only faults on a user-mode request; a supervisor-mode request may use a user entry, subject to R4.
- R6: A write to an entry that is writable but clean (dirty bit 0) faults with rsp_first_wr high; after the entry is refilled with dirty 1 the same write hits. rsp_first_wr never rises for other faults.
- R7: When a fill finds no matching and no free entry, it replaces one pseudo-randomly chosen entry: after 17 distinct fills exactly 16 of those mappings hit, including the last one.
- R8: A full flush invalidates every entry; a fill in the same cycle as the flush survives it.
- R9: A per-process flush invalidates only the entries of the named process; entries of other processes still hit.
- R10: A fill takes effect at the next clock: a lookup in the fill cycle sees the old contents, a lookup one cycle later sees the new mapping.
- R11: A fill whose process and page match a valid entry overwrites that entry in place: the new physical page is returned and no other mapping is lost.
- R12: After reset every entry is invalid and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_off | input | 12 | Lookup page offset |
| lk_pid | input | 8 | Lookup process identifier |
| lk_acc | input | 2 | Access code: 00 read, 01 write, 10 execute, 11 reserved |
| lk_super | input | 1 | Requester is in supervisor mode |
| fl_en | input | 1 | Install a mapping |
| fl_vpn | input | 20 | Fill virtual page number |
| fl_pid | input | 8 | Fill process identifier |
| fl_ppn | input | 20 | Fill physical page number |
| fl_rd | input | 1 | Fill read permission |
| fl_wr | input | 1 | Fill write permission |
| fl_ex | input | 1 | Fill execute permission |
| fl_sup | input | 1 | Fill supervisor-only flag |
| fl_dirty | input | 1 | Fill dirty flag (0 traps the first write) |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate entries of one process |
| flush_pid | input | 8 | Process identifier for the per-process flush |
| rsp_valid | output | 1 | Response valid, one cycle after lk_valid |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry refuses the access |
| rsp_first_wr | output | 1 | Fault is a first write to a clean page |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |

## Verification
The hardest state to reach from the ports is a completely full buffer, where the pseudo-random victim choice takes over and the exact entry replaced cannot be predicted from outside. The stimulus fills 16 distinct pages of one process, adds a seventeenth, and then counts hits over all seventeen: exactly one of the first sixteen must be gone while the newest survives. It then refills a resident page with a new frame and recounts, which shows the in-place overwrite neither loses a mapping nor creates a duplicate.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
      logic sup;
   } perm_t;
endpackage

// File: rtl/ptlb_lfsr.sv
module ptlb_lfsr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   logic fb;

   generate
      if (W == 3) begin : g_w3
         assign fb = state[2] ^ state[1];
      end else if (W == 4) begin : g_w4
         assign fb = state[3] ^ state[2];
      end else if (W == 5) begin : g_w5
         assign fb = state[4] ^ state[2];
      end else if (W == 6) begin : g_w6
         assign fb = state[5] ^ state[4];
      end else begin : g_bad
         $error("ptlb_lfsr: width %0d has no tap set", W);
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) state <= W'(1);
      else        state <= {state[W-2:0], fb};
   end
endmodule

// File: rtl/ptlb_match.sv
module ptlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [VPN_W-1:0]   tag_vpn [ENTRIES],
   input  logic [PID_W-1:0]   tag_pid [ENTRIES],
   input  logic [VPN_W-1:0]   q_vpn,
   input  logic [PID_W-1:0]   q_pid,
   output logic [ENTRIES-1:0] match
);
   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign match[e] = valid[e] && (tag_vpn[e] == q_vpn) && (tag_pid[e] == q_pid);
      end
   endgenerate
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic [ENTRIES-1:0] same_tag,
   input  logic [ENTRIES-1:0] valid,
   input  logic [IDX_W-1:0]   rnd,
   output logic [IDX_W-1:0]   idx
);
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      any_free = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (same_tag[e]) hit_idx = hit_idx | IDX_W'(e);
      end
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid[e]) begin
            free_idx = IDX_W'(e);
            any_free = 1'b1;
         end
      end
      if (|same_tag)    idx = hit_idx;
      else if (any_free) idx = free_idx;
      else               idx = rnd;
   end
endmodule

// File: rtl/ptlb_perm.sv
module ptlb_perm
   import ptlb_pkg::*;
(
   input  perm_t      perm,
   input  logic       dirty,
   input  logic [1:0] acc,
   input  logic       req_super,
   output logic       fault,
   output logic       first_wr
);
   logic bad;

   always_comb begin
      bad = perm.sup && !req_super;
      case (acc)
         ACC_READ:  bad = bad | !perm.rd;
         ACC_WRITE: bad = bad | !perm.wr;
         ACC_EXEC:  bad = bad | !perm.ex;
         default:   bad = 1'b1;
      endcase
      first_wr = !bad && (acc == ACC_WRITE) && !dirty;
      fault    = bad | first_wr;
   end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
   import ptlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int OFF_W   = 12,
   parameter int PID_W   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic [VPN_W-1:0]       lk_vpn,
   input  logic [OFF_W-1:0]       lk_off,
   input  logic [PID_W-1:0]       lk_pid,
   input  logic [1:0]             lk_acc,
   input  logic                   lk_super,
   input  logic                   fl_en,
   input  logic [VPN_W-1:0]       fl_vpn,
   input  logic [PID_W-1:0]       fl_pid,
   input  logic [PPN_W-1:0]       fl_ppn,
   input  logic                   fl_rd,
   input  logic                   fl_wr,
   input  logic                   fl_ex,
   input  logic                   fl_sup,
   input  logic                   fl_dirty,
   input  logic                   flush_all,
   input  logic                   flush_pid_en,
   input  logic [PID_W-1:0]       flush_pid,
   output logic                   rsp_valid,
   output logic                   rsp_hit,
   output logic                   rsp_miss,
   output logic                   rsp_fault,
   output logic                   rsp_first_wr,
   output logic [PPN_W+OFF_W-1:0] rsp_paddr
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int PA_W  = PPN_W + OFF_W;

   generate
      if (ENTRIES != (1 << IDX_W)) begin : g_chk_pow2
         $error("ptag_tlb: ENTRIES must be a power of two");
      end
      if (IDX_W < 3 || IDX_W > 6) begin : g_chk_range
         $error("ptag_tlb: ENTRIES must be between 8 and 64");
      end
   endgenerate

   logic [ENTRIES-1:0] ent_valid;
   logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
   logic [PID_W-1:0]   ent_pid   [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn   [ENTRIES];
   perm_t              ent_perm  [ENTRIES];
   logic [ENTRIES-1:0] ent_dirty;

   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] fl_match;
   logic [IDX_W-1:0]   rnd;
   logic [IDX_W-1:0]   fill_idx;

   ptlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cmp (
      .valid(ent_valid), .tag_vpn(ent_vpn), .tag_pid(ent_pid),
      .q_vpn(lk_vpn), .q_pid(lk_pid), .match(lk_match));

   ptlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_cmp (
      .valid(ent_valid), .tag_vpn(ent_vpn), .tag_pid(ent_pid),
      .q_vpn(fl_vpn), .q_pid(fl_pid), .match(fl_match));

   ptlb_lfsr #(.W(IDX_W)) u_rnd (.clk(clk), .rst_n(rst_n), .state(rnd));

   ptlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vict (
      .same_tag(fl_match), .valid(ent_valid), .rnd(rnd), .idx(fill_idx));

   // Entry storage: flushes clear first, a fill in the same cycle wins.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (flush_all || (flush_pid_en && ent_pid[e] == flush_pid))
               ent_valid[e] <= 1'b0;
            if (fl_en && fill_idx == IDX_W'(e)) begin
               ent_valid[e] <= 1'b1;
               ent_vpn[e]   <= fl_vpn;
               ent_pid[e]   <= fl_pid;
               ent_ppn[e]   <= fl_ppn;
               ent_perm[e]  <= '{rd: fl_rd, wr: fl_wr, ex: fl_ex, sup: fl_sup};
               ent_dirty[e] <= fl_dirty;
            end
         end
      end
   end

   // Select the matching entry (at most one can match).
   logic [PPN_W-1:0] sel_ppn;
   perm_t            sel_perm;
   logic             sel_dirty;
   logic             any_hit;

   always_comb begin
      sel_ppn   = '0;
      sel_perm  = '0;
      sel_dirty = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (lk_match[e]) begin
            sel_ppn   = sel_ppn | ent_ppn[e];
            sel_perm  = sel_perm | ent_perm[e];
            sel_dirty = sel_dirty | ent_dirty[e];
         end
      end
      any_hit = |lk_match;
   end

   logic perm_fault;
   logic perm_first;

   ptlb_perm u_perm (
      .perm(sel_perm), .dirty(sel_dirty), .acc(lk_acc), .req_super(lk_super),
      .fault(perm_fault), .first_wr(perm_first));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_first_wr <= 1'b0;
         rsp_paddr    <= '0;
      end else begin
         rsp_valid    <= lk_valid;
         rsp_hit      <= lk_valid && any_hit && !perm_fault;
         rsp_miss     <= lk_valid && !any_hit;
         rsp_fault    <= lk_valid && any_hit && perm_fault;
         rsp_first_wr <= lk_valid && any_hit && perm_first;
         rsp_paddr    <= (lk_valid && any_hit && !perm_fault) ? {sel_ppn, lk_off} : PA_W'(0);
      end
   end
endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int PA_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               fl_en,
   input logic               flush_all,
   input logic [ENTRIES-1:0] ent_valid,
   input logic [ENTRIES-1:0] lk_match,
   input logic [IDX_W-1:0]   rnd,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_fault,
   input logic               rsp_first_wr,
   input logic [PA_W-1:0]    rsp_paddr
);
   a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);
   a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_miss, rsp_fault}));
   a_r1_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> rsp_paddr == '0);
   a_r6_first_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_first_wr |-> rsp_fault);
   a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all && !fl_en |=> ent_valid == '0);
   a_r7_rnd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      rnd != '0);
endmodule

bind ptag_tlb ptag_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fl_en(fl_en), .flush_all(flush_all),
   .ent_valid(ent_valid), .lk_match(lk_match), .rnd(rnd),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
   .rsp_first_wr(rsp_first_wr), .rsp_paddr(rsp_paddr));

// File: tb/ptag_tlb_bench.sv
`timescale 1ns/1ps
module ptag_tlb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [11:0] lk_off = '0;
   logic [7:0]  lk_pid = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_super = 1'b0;
   logic        fl_en = 1'b0;
   logic [19:0] fl_vpn = '0;
   logic [7:0]  fl_pid = '0;
   logic [19:0] fl_ppn = '0;
   logic        fl_rd = 1'b0, fl_wr = 1'b0, fl_ex = 1'b0, fl_sup = 1'b0, fl_dirty = 1'b0;
   logic        flush_all = 1'b0;
   logic        flush_pid_en = 1'b0;
   logic [7:0]  flush_pid = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_first_wr;
   logic [31:0] rsp_paddr;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   ptag_tlb u_ptag_tlb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
      .lk_pid(lk_pid), .lk_acc(lk_acc), .lk_super(lk_super), .fl_en(fl_en),
      .fl_vpn(fl_vpn), .fl_pid(fl_pid), .fl_ppn(fl_ppn), .fl_rd(fl_rd), .fl_wr(fl_wr),
      .fl_ex(fl_ex), .fl_sup(fl_sup), .fl_dirty(fl_dirty), .flush_all(flush_all),
      .flush_pid_en(flush_pid_en), .flush_pid(flush_pid), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_first_wr(rsp_first_wr), .rsp_paddr(rsp_paddr));

   // Vector: req(4) vpn(20) pid(8) acc(2) super(1) hit(1) fault(1) first(1) ppn(20)
   localparam int NV = 13;
   localparam logic [57:0] VEC [NV] = '{
      {4'd1, 20'h00010, 8'd1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 20'hA0010}, // R1 read hit
      {4'd4, 20'h00010, 8'd1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // R4 no write bit
      {4'd4, 20'h00010, 8'd1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // R4 no exec bit
      {4'd4, 20'h00010, 8'd1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // R4 reserved code
      {4'd2, 20'h00010, 8'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // R2 other pid
      {4'd2, 20'h00010, 8'd2, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 20'hB0010}, // R2 pid 2 own entry
      {4'd6, 20'h00020, 8'd1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 20'h0},     // R6 first write
      {4'd6, 20'h00020, 8'd1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 20'hA0020}, // R6 read of clean page
      {4'd5, 20'h00030, 8'd1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // R5 user on sup page
      {4'd5, 20'h00030, 8'd1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 20'hA0030}, // R5 sup on sup page
      {4'd5, 20'h00010, 8'd1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 20'hA0010}, // R5 sup on user page
      {4'd5, 20'h00030, 8'd1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 20'h0},     // R5 sup still needs rd
      {4'd2, 20'h00011, 8'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0}      // R2 neighbour page
   };

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Called at a negedge; returns at the next negedge.
   task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] ppn,
                       input logic rd, input logic wr, input logic ex, input logic sup,
                       input logic dirty);
      fl_en = 1'b1; fl_vpn = vpn; fl_pid = pid; fl_ppn = ppn;
      fl_rd = rd; fl_wr = wr; fl_ex = ex; fl_sup = sup; fl_dirty = dirty;
      @(negedge clk);
      fl_en = 1'b0;
   endtask

   task automatic lookup(input logic [19:0] vpn, input logic [7:0] pid, input logic [1:0] acc,
                         input logic sup);
      lk_valid = 1'b1; lk_vpn = vpn; lk_pid = pid; lk_acc = acc; lk_super = sup;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic expect_rsp(string req, logic hit, logic fault, logic first, logic [19:0] ppn);
      check(req, "valid", rsp_valid, 1);
      check(req, "hit", rsp_hit, hit);
      check(req, "miss", rsp_miss, !hit && !fault);
      check(req, "fault", rsp_fault, fault);
      check(req, "first_wr", rsp_first_wr, first);
      check(req, "paddr", rsp_paddr, hit ? {ppn, lk_off} : 32'h0);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int hits;
      repeat (3) @(negedge clk);
      // R12: outputs low in reset
      check("R12", "reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_first_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      lk_off = 12'h5A5;
      lookup(20'h00010, 8'd1, 2'b00, 1'b0);
      expect_rsp("R12", 0, 0, 0, 0);   // empty after reset

      // R10: lookup in fill cycle sees old contents, next cycle sees the mapping
      fl_en = 1'b1; fl_vpn = 20'h00010; fl_pid = 8'd1; fl_ppn = 20'hA0010;
      fl_rd = 1; fl_wr = 0; fl_ex = 0; fl_sup = 0; fl_dirty = 1;
      lookup(20'h00010, 8'd1, 2'b00, 1'b0);
      fl_en = 1'b0;
      expect_rsp("R10", 0, 0, 0, 0);
      lookup(20'h00010, 8'd1, 2'b00, 1'b0);
      expect_rsp("R10", 1, 0, 0, 20'hA0010);

      fill(20'h00020, 8'd1, 20'hA0020, 1, 1, 0, 0, 0);
      fill(20'h00030, 8'd1, 20'hA0030, 0, 0, 1, 1, 1);
      fill(20'h00010, 8'd2, 20'hB0010, 1, 1, 0, 0, 1);

      for (int i = 0; i < NV; i++) begin
         logic [57:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d", v[57:54]);
         lookup(v[53:34], v[33:26], v[25:24], v[23]);
         expect_rsp(tag, v[22], v[21], v[20], v[19:0]);
      end

      // R6: refill as dirty, write now hits
      fill(20'h00020, 8'd1, 20'hA0020, 1, 1, 0, 0, 1);
      lookup(20'h00020, 8'd1, 2'b01, 1'b0);
      expect_rsp("R6", 1, 0, 0, 20'hA0020);

      // R9: flush process 1 only
      flush_pid_en = 1'b1; flush_pid = 8'd1;
      @(negedge clk);
      flush_pid_en = 1'b0;
      lookup(20'h00010, 8'd1, 2'b00, 1'b0);
      expect_rsp("R9", 0, 0, 0, 0);
      lookup(20'h00010, 8'd2, 2'b00, 1'b0);
      expect_rsp("R9", 1, 0, 0, 20'hB0010);

      // R8: full flush with a simultaneous fill that survives
      flush_all = 1'b1;
      fill(20'h00040, 8'd4, 20'hC0040, 1, 0, 0, 0, 1);
      flush_all = 1'b0;
      lookup(20'h00010, 8'd2, 2'b00, 1'b0);
      expect_rsp("R8", 0, 0, 0, 0);
      lookup(20'h00040, 8'd4, 2'b00, 1'b0);
      expect_rsp("R8", 1, 0, 0, 20'hC0040);

      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;

      // R3: sixteen distinct mappings all resident
      for (int v = 0; v < 16; v++)
         fill(20'h00100 + 20'(v), 8'd5, 20'hD0000 + 20'(v), 1, 0, 0, 0, 1);
      hits = 0;
      for (int v = 0; v < 16; v++) begin
         lookup(20'h00100 + 20'(v), 8'd5, 2'b00, 1'b0);
         if (rsp_hit && rsp_paddr == {20'hD0000 + 20'(v), lk_off}) hits++;
      end
      check("R3", "hits with 16 fills", hits, 16);

      // R7: seventeenth fill evicts exactly one
      fill(20'h00110, 8'd5, 20'hD0010, 1, 0, 0, 0, 1);
      hits = 0;
      for (int v = 0; v < 17; v++) begin
         lookup(20'h00100 + 20'(v), 8'd5, 2'b00, 1'b0);
         if (rsp_hit) hits++;
      end
      check("R7", "hits after 17 fills", hits, 16);
      lookup(20'h00110, 8'd5, 2'b00, 1'b0);
      expect_rsp("R7", 1, 0, 0, 20'hD0010);

      // R11: refill a resident page in place
      fill(20'h00110, 8'd5, 20'hE0110, 1, 0, 0, 0, 1);
      lookup(20'h00110, 8'd5, 2'b00, 1'b0);
      expect_rsp("R11", 1, 0, 0, 20'hE0110);
      hits = 0;
      for (int v = 0; v < 17; v++) begin
         lookup(20'h00100 + 20'(v), 8'd5, 2'b00, 1'b0);
         if (rsp_hit) hits++;
      end
      check("R11", "hits after in-place refill", hits, 16);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule